// File: doc/BRIEF.md
# Duty-Programmable Serial Clock Generator

This block derives a serial-interface clock from the system clock through two cascaded dividers. A prescaler stretches each step of a small phase counter over a programmable number of system cycles. The phase counter walks through one output period, and two programmable points inside that period place the clock's high and low intervals, so the duty cycle is chosen by software rather than fixed at one half. For the fastest rates a bypass bit hands the system clock straight to the output.

Besides the clock itself, the block gives a transaction sequencer two single-cycle strobes, one for each rising and one for each falling transition of the generated clock. New settings are taken only when a period ends, so changing them never produces a runt pulse. Software chooses the divider values. The block only applies them.

Top module: `sclk_divider`

## Requirements
- R1: After reset the clock output `sclk_o` and both edge ticks are low.
- R2: While `en_i` is low, `sclk_o` and `rise_tick_o` stay low and the counters are held at zero.
- R3: The configuration word is {bypass at bit 31, prescale-minus-one at [30:18], period-minus-one at [17:12], high-point-minus-one at [11:6], low-point-minus-one at [5:0]}. With bypass clear, one output period lasts P*N system cycles, where P is the prescale field plus one (1 to 8192) and N is the period field plus one (1 to 64).
- R4: Each period starts high. The clock is high for phase counts 0 to H-1 and low from count H up to the low point L. With L equal to N, this gives H*P high cycles and (N-H)*P low cycles.
- R5: When the low point L is below N, the clock goes high again for phase counts L to N-1.
- R6: A high-point field of zero gives exactly one phase count of high level per period.
- R7: A change of the configuration word takes effect only at the next period boundary. The period in progress completes with the old settings.
- R8: With bypass set and `en_i` high, `sclk_o` follows the system clock, all divider fields are ignored, and both ticks are high in every cycle. Bypass is left within one cycle of clearing the bit.
- R9: With bypass clear, `rise_tick_o` is high for exactly the one cycle in which `sclk_o` has just gone from 0 to 1, and `fall_tick_o` for the one cycle in which it has just gone from 1 to 0.
- R10: The first system-clock edge that samples `en_i` high drives `sclk_o` high together with a rise tick. The first high interval has its full length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Run enable; low holds the output low |
| cfg_i | input | 32 | Configuration word (fields listed in R3) |
| sclk_o | output | 1 | Generated serial clock |
| rise_tick_o | output | 1 | One-cycle strobe on each rising transition of `sclk_o` |
| fall_tick_o | output | 1 | One-cycle strobe on each falling transition of `sclk_o` |

## Verification
In divided mode `sclk_o` and both ticks come from registers. They move one edge after the counters decide, so the first edge that samples the enable shows the clock high at the following falling edge. The bench drives and samples only on falling edges. It measures high and low intervals by counting the falling edges between a rise tick and the next fall tick, which counts the registered delay exactly once. A configuration change is applied right after a rise tick and is expected only after the whole old period has run out. In bypass the output follows the clock within the same cycle, so it is sampled low at the falling edge and high shortly after the rising edge.

// File: rtl/sclkdiv_pkg.sv
package sclkdiv_pkg;
    localparam int PRE_W = 13;
    localparam int CNT_W = 6;
    localparam int CFG_W = 1 + PRE_W + 3 * CNT_W;

    typedef struct packed {
        logic             bypass;
        logic [PRE_W-1:0] pre_m1;
        logic [CNT_W-1:0] period_m1;
        logic [CNT_W-1:0] high_m1;
        logic [CNT_W-1:0] low_m1;
    } div_cfg_t;
endpackage

// File: rtl/sclkdiv_prescale.sv
module sclkdiv_prescale #(
    parameter int W = 13
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         clear_i,
    input  logic [W-1:0] limit_i,
    output logic         strobe_o
);
    typedef struct packed {
        logic [W-1:0] cnt;
    } pre_st_t;

    pre_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        strobe_o = !clear_i && (st_q.cnt == limit_i);
        if (clear_i || strobe_o) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end
endmodule

// File: rtl/sclkdiv_phase.sv
module sclkdiv_phase #(
    parameter int W = 6
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         clear_i,
    input  logic         step_i,
    input  logic [W-1:0] period_m1_i,
    input  logic [W-1:0] high_m1_i,
    input  logic [W-1:0] low_m1_i,
    output logic         wrap_o,
    output logic         level_next_o
);
    typedef struct packed {
        logic [W-1:0] cnt;
    } ph_st_t;

    ph_st_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        wrap_o = !clear_i && step_i && (st_q.cnt == period_m1_i);
        if (clear_i || wrap_o) begin
            st_d.cnt = '0;
        end else if (step_i) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
        // high up to the high point, high again past the low point
        level_next_o = (st_d.cnt <= high_m1_i) || (st_d.cnt > low_m1_i);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end
endmodule

// File: rtl/sclk_divider.sv
module sclk_divider
    import sclkdiv_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             en_i,
    input  logic [CFG_W-1:0] cfg_i,
    output logic             sclk_o,
    output logic             rise_tick_o,
    output logic             fall_tick_o
);
    typedef struct packed {
        div_cfg_t act;
        logic     run;
        logic     sclk;
        logic     byp;
        logic     rise;
        logic     fall;
    } top_st_t;

    top_st_t  st_d, st_q;
    div_cfg_t cfg_in;
    logic     clear, step, wrap, level_next, boundary;
    logic     sclk_q, byp_q;

    assign cfg_in = div_cfg_t'(cfg_i);
    assign clear  = !en_i || !st_q.run || st_q.act.bypass;

    sclkdiv_prescale #(.W(PRE_W)) u_pre (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .clear_i  (clear),
        .limit_i  (st_q.act.pre_m1),
        .strobe_o (step)
    );

    sclkdiv_phase #(.W(CNT_W)) u_phase (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .clear_i      (clear),
        .step_i       (step),
        .period_m1_i  (st_q.act.period_m1),
        .high_m1_i    (st_q.act.high_m1),
        .low_m1_i     (st_q.act.low_m1),
        .wrap_o       (wrap),
        .level_next_o (level_next)
    );

    always_comb begin
        st_d     = st_q;
        boundary = clear || wrap;
        if (boundary) st_d.act = cfg_in;
        st_d.run  = en_i;
        st_d.byp  = en_i && st_d.act.bypass;
        st_d.sclk = en_i && !st_d.act.bypass && level_next;
        st_d.rise = st_d.byp || (st_d.sclk && !st_q.sclk);
        st_d.fall = st_d.byp || (!st_d.sclk && st_q.sclk);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign sclk_q      = st_q.sclk;
    assign byp_q       = st_q.byp;
    assign sclk_o      = byp_q ? clk_i : sclk_q;
    assign rise_tick_o = st_q.rise;
    assign fall_tick_o = st_q.fall;
endmodule

// File: rtl/sclkdiv_checker.sv
module sclkdiv_checker (
    input logic clk_i,
    input logic rst_ni,
    input logic en_i,
    input logic sclk_q,
    input logic byp_q,
    input logic rise_i,
    input logic fall_i
);
    // R2: disabled means quiet
    a_r2_off_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !en_i |=> (!sclk_q && !rise_i && !byp_q));

    // R9: rise tick sits on a 0-to-1 transition
    a_r9_rise_aligned: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rise_i && !byp_q) |-> (sclk_q && !$past(sclk_q)));

    // R9: fall tick sits on a 1-to-0 transition
    a_r9_fall_aligned: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (fall_i && !byp_q) |-> (!sclk_q && $past(sclk_q)));

    // R9: every transition carries a tick
    a_r9_edge_ticked: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sclk_q != $past(sclk_q)) |-> (rise_i || fall_i));

    // R8: bypass raises both ticks every cycle
    a_r8_byp_ticks: assert property (@(posedge clk_i) disable iff (!rst_ni)
        byp_q |-> (rise_i && fall_i && !sclk_q));
endmodule

bind sclk_divider sclkdiv_checker u_chk (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en_i),
    .sclk_q (sclk_q),
    .byp_q  (byp_q),
    .rise_i (rise_tick_o),
    .fall_i (fall_tick_o)
);

// File: tb/sim_sclk_divider.sv
`timescale 1ns/1ps
module sim_sclk_divider;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0;
    logic [31:0] cfg = '0;
    logic        sclk, rise, fall;
    int          n_chk = 0;
    int          n_err = 0;
    bit          done = 1'b0;

    always #4 clk = ~clk;

    sclk_divider u0 (
        .clk_i(clk), .rst_ni(rst_n), .en_i(en), .cfg_i(cfg),
        .sclk_o(sclk), .rise_tick_o(rise), .fall_tick_o(fall)
    );

    function automatic logic [31:0] mk(bit byp, int p, int n, int h, int l);
        return {byp, 13'(p - 1), 6'(n - 1), 6'(h - 1), 6'(l - 1)};
    endfunction

    task automatic check(bit ok, string tag, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic report();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
            $finish;
        end
    endtask

    // count from a rise cycle: high cycles, then low cycles
    task automatic count_hl(string tag, int eh, int el);
        int hi = 0;
        int lo = 0;
        while (sclk && hi < 20000) begin hi++; @(negedge clk); end
        check(fall === 1'b1, {tag, " R9 fall tick"}, fall, 1);
        while (!sclk && lo < 20000) begin lo++; @(negedge clk); end
        check(rise === 1'b1, {tag, " R9 rise tick"}, rise, 1);
        check(hi == eh, {tag, " high cycles"}, hi, eh);
        check(lo == el, {tag, " low cycles"}, lo, el);
    endtask

    task automatic start(logic [31:0] c);
        en = 1'b0;
        @(negedge clk);
        cfg = c;
        en  = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_reset();
        check(sclk === 1'b0 && rise === 1'b0 && fall === 1'b0, "R1 reset outputs", {sclk, rise, fall}, 0);
    endtask

    task automatic t_disabled();
        int bad = 0;
        cfg = mk(0, 1, 2, 1, 2);
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (sclk !== 1'b0 || rise !== 1'b0) bad++;
        end
        check(bad == 0, "R2 output while disabled", bad, 0);
    endtask

    task automatic t_basic(string tag, int p, int n, int h, int eh, int el);
        start(mk(0, p, n, h, n));
        check(sclk === 1'b1 && rise === 1'b1, {tag, " R10 first edge"}, sclk, 1);
        count_hl({tag, " R10 first period"}, eh, el);
        count_hl({tag, " R3 R4 steady period"}, eh, el);
    endtask

    task automatic t_lowpoint();
        start(mk(0, 1, 6, 2, 4));
        count_hl("R5 first period", 2, 2);
        count_hl("R5 re-high past low point", 4, 2);
    endtask

    task automatic t_change();
        start(mk(0, 2, 4, 1, 4));
        cfg = mk(0, 1, 3, 2, 3);
        count_hl("R7 old period kept", 2, 6);
        count_hl("R7 new period applied", 2, 1);
    endtask

    task automatic t_bypass();
        int bad = 0;
        start(mk(1, 4660, 1, 10, 4));
        @(negedge clk);
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            if (sclk !== 1'b0 || rise !== 1'b1 || fall !== 1'b1) bad++;
            @(posedge clk); #1;
            if (sclk !== 1'b1) bad++;
        end
        check(bad == 0, "R8 bypass follows clock with ticks", bad, 0);
        @(negedge clk);
        cfg = mk(0, 1, 2, 1, 2);
        @(negedge clk);
        check(sclk === 1'b1 && rise === 1'b1, "R8 leave bypass", sclk, 1);
        count_hl("R8 divided after bypass", 1, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_disabled();
        t_basic("fastest", 1, 2, 1, 1, 1);
        t_basic("p3n5h2", 3, 5, 2, 6, 9);
        t_basic("maxperiod", 1, 64, 32, 32, 32);
        t_basic("R6 minhigh", 2, 4, 1, 2, 6);
        t_lowpoint();
        t_change();
        t_bypass();
        t_basic("maxprescale", 8192, 2, 1, 8192, 8192);
        en = 1'b0;
        repeat (2) @(negedge clk);
        check(sclk === 1'b0, "R2 low after disable", sclk, 0);
        report();
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 200000, 0);
        report();
    end
endmodule